// File: doc/BRIEF.md
# Fragmented Message Sequence Checker

This block follows the reassembly of fragmented messages for a bank of receive message objects on a CAN-style controller. Upstream logic decodes each received frame and presents it as one valid pulse. The pulse carries the target object number, a start-of-message marker, the fragment count taken from the frame and the number of data bytes. For each object the block keeps an assembly state, the last accepted fragment count and a byte write pointer into that object's buffer. For each accepted frame it emits the buffer address at which the frame's bytes belong.

The fragment count is checked modulo a width chosen by a protocol mode: six bits, four bits, or a single bit that must toggle. A frame whose count is not the previous count plus one is a sequence fault. On a fault the object stops assembling and the block raises a message-error interrupt. The interrupt is also raised by a transmit-underflow event reported from outside. A small info record names the last failing object and the kind of error. Software clears the interrupt by writing one to bit 3 of the interrupt flag word. A start-of-message arriving in the middle of an assembly rewinds that object's pointer without any error.

Top module: `frag_seq_checker`

## Requirements
- R1: After reset, `irq_merr`, `ptr_valid`, `info_obj` and `info_type` are all 0, and every object is idle.
- R2: A frame with `frm_som`=1 is accepted whatever its count. One cycle later it gives `ptr_valid`=1, `ptr_obj`=object and `ptr_addr`=0. The object's pointer becomes `frm_len`, and its count is recorded.
- R3: A continuation frame (`frm_som`=0) for an assembling object whose count equals the recorded count plus one, modulo the mode width, is accepted. One cycle later `ptr_addr` equals the object's current pointer. The pointer then advances by `frm_len`.
- R4: Mode `mode`=00 compares `frm_cnt[5:0]`. Mode 01 compares `frm_cnt[3:0]` and ignores the upper bits. Mode 10 compares only `frm_cnt[0]`, which must toggle. Mode 11 behaves as 00. The maximum count followed by 0 is legal.
- R5: A continuation frame with any other count gives no `ptr_valid`. One cycle later it sets `irq_merr`=1, `info_obj`=object and `info_type`=0 (fragmentation).
- R6: After a fault, the object's continuation frames are dropped until its next start-of-message. Dropped frames give no `ptr_valid` and raise no new error.
- R7: A start-of-message for an object already mid-assembly rewinds its pointer to 0 and restarts assembly. It does not set `irq_merr`.
- R8: A `txu_valid` pulse sets `irq_merr` and records `info_obj`=`txu_obj`, `info_type`=1 (underflow). A later error overwrites the info record.
- R9: A write (`irq_wr`=1) with `irq_wdata[3]`=1 clears `irq_merr`. Other data bits have no effect. A new error in the same cycle wins over the clear.
- R10: When a fragmentation error and an underflow occur in the same cycle, the info record holds the fragmentation error.
- R11: A continuation frame for an object that has never started is dropped silently. Each object's state is independent of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Protocol mode selecting the fragment count width |
| frm_valid | input | 1 | Decoded frame present this cycle |
| frm_obj | input | 5 | Target message object |
| frm_som | input | 1 | Frame starts a new message |
| frm_cnt | input | 6 | Fragment count from the frame |
| frm_len | input | 4 | Data bytes in the frame |
| txu_valid | input | 1 | Transmit underflow event |
| txu_obj | input | 5 | Object that suffered the underflow |
| irq_wr | input | 1 | Write strobe to the interrupt flag word |
| irq_wdata | input | 8 | Write data; bit 3 set clears the message-error flag |
| ptr_valid | output | 1 | Accepted frame address valid |
| ptr_obj | output | 5 | Object of the accepted frame |
| ptr_addr | output | 8 | Buffer byte address for the accepted frame |
| irq_merr | output | 1 | Message-error interrupt flag |
| info_obj | output | 5 | Object of the last recorded error |
| info_type | output | 1 | Last error type: 0 fragmentation, 1 underflow |

## Verification
A wrong stored pointer is visible on `ptr_addr` on the very next accepted frame for that object, one cycle after the frame. That is why the tests check address sequences across several fragments. A stale or wrong count, or a lost assembly state, shows up one cycle after the next continuation frame. It appears either as a spurious `irq_merr` or as a missing `ptr_valid`. The tests also interleave objects so that state leaking between them shows at the ports.

// File: rtl/frag_seq_checker.sv
module frag_seq_checker #(
  parameter int NUM_OBJ = 32,
  parameter int CNT_W   = 6,
  parameter int PTR_W   = 8,
  parameter int LEN_W   = 4,
  parameter int IRQ_W   = 8,
  parameter int IRQ_BIT = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode,
  input  logic                       frm_valid,
  input  logic [$clog2(NUM_OBJ)-1:0] frm_obj,
  input  logic                       frm_som,
  input  logic [CNT_W-1:0]           frm_cnt,
  input  logic [LEN_W-1:0]           frm_len,
  input  logic                       txu_valid,
  input  logic [$clog2(NUM_OBJ)-1:0] txu_obj,
  input  logic                       irq_wr,
  input  logic [IRQ_W-1:0]           irq_wdata,
  output logic                       ptr_valid,
  output logic [$clog2(NUM_OBJ)-1:0] ptr_obj,
  output logic [PTR_W-1:0]           ptr_addr,
  output logic                       irq_merr,
  output logic [$clog2(NUM_OBJ)-1:0] info_obj,
  output logic                       info_type
);
  localparam int OBJ_W = $clog2(NUM_OBJ);
  localparam logic [CNT_W-1:0] MASK_W6 = CNT_W'(6'h3F);
  localparam logic [CNT_W-1:0] MASK_W4 = CNT_W'(4'hF);
  localparam logic [CNT_W-1:0] MASK_W1 = CNT_W'(1'b1);

  logic [PTR_W-1:0] wptr_q  [NUM_OBJ];
  logic [CNT_W-1:0] last_q  [NUM_OBJ];
  logic [NUM_OBJ-1:0] busy_q;

  logic [CNT_W-1:0] cmask, want;
  logic live, seq_ok, take_cont, frag_err, irq_set, irq_clr;

  assign cmask = (mode == 2'b01) ? MASK_W4 :
                 (mode == 2'b10) ? MASK_W1 : MASK_W6;
  assign want      = (last_q[frm_obj] + CNT_W'(1)) & cmask;
  assign seq_ok    = (frm_cnt & cmask) == want;
  assign live      = busy_q[frm_obj];
  assign take_cont = frm_valid && !frm_som && live && seq_ok;
  assign frag_err  = frm_valid && !frm_som && live && !seq_ok;
  assign irq_set   = frag_err || txu_valid;
  assign irq_clr   = irq_wr && irq_wdata[IRQ_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= '0;
      ptr_valid <= 1'b0;
      ptr_obj   <= '0;
      ptr_addr  <= '0;
      irq_merr  <= 1'b0;
      info_obj  <= '0;
      info_type <= 1'b0;
      for (int i = 0; i < NUM_OBJ; i++) begin
        wptr_q[i] <= '0;
        last_q[i] <= '0;
      end
    end else begin
      ptr_valid <= frm_valid && (frm_som || take_cont);
      if (frm_valid) ptr_obj <= frm_obj;
      if (frm_valid && frm_som) begin
        busy_q[frm_obj] <= 1'b1;
        wptr_q[frm_obj] <= PTR_W'(frm_len);
        last_q[frm_obj] <= frm_cnt;
        ptr_addr        <= '0;
      end else if (take_cont) begin
        wptr_q[frm_obj] <= wptr_q[frm_obj] + PTR_W'(frm_len);
        last_q[frm_obj] <= frm_cnt;
        ptr_addr        <= wptr_q[frm_obj];
      end else if (frag_err) begin
        busy_q[frm_obj] <= 1'b0;
      end
      if (irq_set)      irq_merr <= 1'b1;
      else if (irq_clr) irq_merr <= 1'b0;
      if (frag_err) begin
        info_obj  <= frm_obj;
        info_type <= 1'b0;
      end else if (txu_valid) begin
        info_obj  <= txu_obj;
        info_type <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frag_seq_checker_sva.sv
module frag_seq_checker_sva #(
  parameter int OBJ_W   = 5,
  parameter int PTR_W   = 8,
  parameter int IRQ_W   = 8,
  parameter int IRQ_BIT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic [OBJ_W-1:0] frm_obj,
  input logic             frm_som,
  input logic             txu_valid,
  input logic             irq_wr,
  input logic [IRQ_W-1:0] irq_wdata,
  input logic             ptr_valid,
  input logic [OBJ_W-1:0] ptr_obj,
  input logic [PTR_W-1:0] ptr_addr,
  input logic             irq_merr,
  input logic             info_type
);
  // R2: a start frame is always accepted at address zero
  assert_som_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_som |=> ptr_valid && ptr_addr == '0 && ptr_obj == $past(frm_obj));

  // R3: an address is only produced for a frame presented the cycle before
  assert_ptr_from_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_valid |-> $past(frm_valid));

  // R7: a restart never raises the interrupt
  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_som && !txu_valid && !irq_merr |=> !irq_merr);

  // R8: an underflow always sets the flag and records its type
  assert_txu_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txu_valid && !(frm_valid && !frm_som) |=> irq_merr && info_type);

  // R9: the flag holds until a write-one-to-clear
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_merr && !(irq_wr && irq_wdata[IRQ_BIT]) |=> irq_merr);

  // R9: a clear with no new error drops the flag
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr && irq_wdata[IRQ_BIT] && !txu_valid && !frm_valid |=> !irq_merr);

  // R5: the flag only rises after a frame or underflow event
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_merr) |-> $past(frm_valid || txu_valid));
endmodule

bind frag_seq_checker frag_seq_checker_sva #(
  .OBJ_W(OBJ_W), .PTR_W(PTR_W), .IRQ_W(IRQ_W), .IRQ_BIT(IRQ_BIT)
) u_sva (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_obj(frm_obj),
  .frm_som(frm_som), .txu_valid(txu_valid), .irq_wr(irq_wr),
  .irq_wdata(irq_wdata), .ptr_valid(ptr_valid), .ptr_obj(ptr_obj),
  .ptr_addr(ptr_addr), .irq_merr(irq_merr), .info_type(info_type)
);

// File: tb/frag_seq_checker_tb.sv
module frag_seq_checker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic frm_valid = 1'b0, frm_som = 1'b0;
  logic [4:0] frm_obj = '0, txu_obj = '0;
  logic [5:0] frm_cnt = '0;
  logic [3:0] frm_len = '0;
  logic txu_valid = 1'b0, irq_wr = 1'b0;
  logic [7:0] irq_wdata = '0;
  logic ptr_valid, irq_merr, info_type;
  logic [4:0] ptr_obj, info_obj;
  logic [7:0] ptr_addr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  frag_seq_checker u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .frm_valid(frm_valid),
    .frm_obj(frm_obj), .frm_som(frm_som), .frm_cnt(frm_cnt), .frm_len(frm_len),
    .txu_valid(txu_valid), .txu_obj(txu_obj), .irq_wr(irq_wr),
    .irq_wdata(irq_wdata), .ptr_valid(ptr_valid), .ptr_obj(ptr_obj),
    .ptr_addr(ptr_addr), .irq_merr(irq_merr), .info_obj(info_obj),
    .info_type(info_type)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then sample at the next falling edge
  task automatic step(input bit fv, input logic [4:0] o, input bit som,
                      input logic [5:0] c, input logic [3:0] l,
                      input bit tv, input logic [4:0] to,
                      input bit w, input logic [7:0] wd);
    @(negedge clk);
    frm_valid = fv; frm_obj = o; frm_som = som; frm_cnt = c; frm_len = l;
    txu_valid = tv; txu_obj = to; irq_wr = w; irq_wdata = wd;
    @(negedge clk);
    frm_valid = 0; txu_valid = 0; irq_wr = 0;
  endtask

  task automatic frame(input logic [4:0] o, input bit som, input logic [5:0] c,
                       input logic [3:0] l);
    step(1, o, som, c, l, 0, 0, 0, 0);
  endtask

  task automatic expect_ptr(input string tag, input logic [4:0] o, input int addr);
    chk(ptr_valid === 1'b1, {tag, " valid"}, ptr_valid, 1);
    chk(ptr_obj == o, {tag, " obj"}, ptr_obj, o);
    chk(ptr_addr == addr[7:0], {tag, " addr"}, ptr_addr, addr);
  endtask

  task automatic expect_drop(input string tag);
    chk(ptr_valid === 1'b0, {tag, " no ptr"}, ptr_valid, 0);
  endtask

  task automatic clear_irq;
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h08);
  endtask

  task automatic t_reset;
    chk(irq_merr === 1'b0, "R1 irq", irq_merr, 0);
    chk(ptr_valid === 1'b0, "R1 ptr_valid", ptr_valid, 0);
    chk(info_obj === 5'd0, "R1 info_obj", info_obj, 0);
    chk(info_type === 1'b0, "R1 info_type", info_type, 0);
  endtask

  task automatic t_basic;
    mode = 2'b00;
    frame(3, 1, 5, 8);  expect_ptr("R2 start", 3, 0);
    frame(3, 0, 6, 8);  expect_ptr("R3 cont1", 3, 8);
    frame(3, 0, 7, 3);  expect_ptr("R3 cont2", 3, 16);
    frame(3, 0, 8, 1);  expect_ptr("R3 cont3", 3, 19);
    chk(irq_merr === 1'b0, "R3 no irq", irq_merr, 0);
  endtask

  task automatic t_wrap6;
    mode = 2'b00;
    frame(4, 1, 63, 2); expect_ptr("R4 w6 start", 4, 0);
    frame(4, 0, 0, 2);  expect_ptr("R4 w6 wrap", 4, 2);
    mode = 2'b11;
    frame(4, 0, 1, 2);  expect_ptr("R4 mode11", 4, 4);
    frame(4, 0, 3, 2);  expect_drop("R4 mode11 six-bit err");
    chk(irq_merr === 1'b1, "R4 mode11 irq", irq_merr, 1);
    clear_irq;
  endtask

  task automatic t_mode4;
    mode = 2'b01;
    frame(5, 1, 15, 4);  expect_ptr("R4 w4 start", 5, 0);
    frame(5, 0, 6'h30, 4); expect_ptr("R4 w4 wrap upper ignored", 5, 4);
    frame(5, 0, 2, 4);   expect_drop("R5 w4 bad");
    chk(irq_merr === 1'b1, "R5 irq", irq_merr, 1);
    chk(info_obj == 5, "R5 info_obj", info_obj, 5);
    chk(info_type === 1'b0, "R5 info_type", info_type, 0);
    clear_irq;
    chk(irq_merr === 1'b0, "R9 clear", irq_merr, 0);
  endtask

  task automatic t_toggle;
    mode = 2'b10;
    frame(6, 1, 0, 8); expect_ptr("R4 t start", 6, 0);
    frame(6, 0, 1, 8); expect_ptr("R4 t toggle1", 6, 8);
    frame(6, 0, 2, 8); expect_ptr("R4 t toggle0", 6, 16);
    frame(6, 0, 0, 8); expect_drop("R4 t repeat");
    chk(irq_merr === 1'b1, "R4 t irq", irq_merr, 1);
    chk(info_obj == 6, "R4 t info_obj", info_obj, 6);
    clear_irq;
  endtask

  task automatic t_discard;
    mode = 2'b00;
    frame(7, 1, 0, 4); expect_ptr("R6 start", 7, 0);
    frame(7, 0, 2, 4); expect_drop("R6 fault");
    chk(irq_merr === 1'b1, "R6 fault irq", irq_merr, 1);
    clear_irq;
    frame(7, 0, 1, 4); expect_drop("R6 drop a");
    frame(7, 0, 3, 4); expect_drop("R6 drop b");
    chk(irq_merr === 1'b0, "R6 no new irq", irq_merr, 0);
    frame(7, 1, 9, 4);  expect_ptr("R6 resume start", 7, 0);
    frame(7, 0, 10, 4); expect_ptr("R6 resume cont", 7, 4);
  endtask

  task automatic t_restart;
    mode = 2'b00;
    frame(8, 1, 0, 5);  expect_ptr("R7 first", 8, 0);
    frame(8, 0, 1, 5);  expect_ptr("R7 cont", 8, 5);
    frame(8, 1, 20, 5); expect_ptr("R7 restart", 8, 0);
    chk(irq_merr === 1'b0, "R7 no irq", irq_merr, 0);
    frame(8, 0, 21, 5); expect_ptr("R7 after restart", 8, 5);
  endtask

  task automatic t_txu;
    step(0, 0, 0, 0, 0, 1, 17, 0, 0);
    chk(irq_merr === 1'b1, "R8 irq", irq_merr, 1);
    chk(info_obj == 17, "R8 info_obj", info_obj, 17);
    chk(info_type === 1'b1, "R8 info_type", info_type, 1);
    step(0, 0, 0, 0, 0, 1, 2, 0, 0);
    chk(info_obj == 2, "R8 overwrite", info_obj, 2);
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'hF7);
    chk(irq_merr === 1'b1, "R9 other bits", irq_merr, 1);
    clear_irq;
    chk(irq_merr === 1'b0, "R9 bit3 clear", irq_merr, 0);
    step(0, 0, 0, 0, 0, 1, 3, 1, 8'h08);
    chk(irq_merr === 1'b1, "R9 set wins", irq_merr, 1);
    chk(info_obj == 3, "R9 set wins obj", info_obj, 3);
    clear_irq;
  endtask

  task automatic t_priority;
    mode = 2'b00;
    frame(9, 1, 0, 1); expect_ptr("R10 start", 9, 0);
    step(1, 9, 0, 5, 1, 1, 2, 0, 0);
    chk(irq_merr === 1'b1, "R10 irq", irq_merr, 1);
    chk(info_obj == 9, "R10 info_obj", info_obj, 9);
    chk(info_type === 1'b0, "R10 info_type", info_type, 0);
    clear_irq;
  endtask

  task automatic t_independent;
    mode = 2'b00;
    frame(20, 0, 1, 3); expect_drop("R11 never started");
    chk(irq_merr === 1'b0, "R11 never started irq", irq_merr, 0);
    frame(10, 1, 0, 2);  expect_ptr("R11 a start", 10, 0);
    frame(11, 1, 30, 3); expect_ptr("R11 b start", 11, 0);
    frame(10, 0, 1, 2);  expect_ptr("R11 a cont", 10, 2);
    frame(11, 0, 31, 3); expect_ptr("R11 b cont", 11, 3);
    chk(irq_merr === 1'b0, "R11 no irq", irq_merr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_wrap6;
    t_mode4;
    t_toggle;
    t_discard;
    t_restart;
    t_txu;
    t_priority;
    t_independent;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule